// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (a clock line and an open-drain data line). It gives an external master access to a bank of 8-bit configuration registers. Both lines pass through a synchroniser into a faster system clock. The block then recognises start and stop conditions, matches its device address, takes a subaddress, and stores write bursts at a pointer that increments after each byte.

Register readback is gated. Read transactions are acknowledged from the start, but the slave puts register contents on the line only after software has set a readback-enable bit by writing a control register. The lowest addresses form a read-only window. It returns an identification byte built from a part code and a revision, followed by six status bytes taken from input pins. A strap pin moves the device address between two values. A read always continues from wherever the pointer was left: either the subaddress just written, or the location after the last byte of a burst.

Top module: `ser_cfg_slave`

## Requirements
- R1: A falling data edge while the clock is high is a start condition, and a rising data edge while the clock is high is a stop condition. A stop returns the slave to idle, and the slave responds to nothing until the next start.
- R2: The 8-bit write address is 0x88 with `addr_sel_i` low and 0x8A with it high, and the read address is the write address plus one. On a match the slave pulls the data line low during the ninth clock. A mismatch is left unacknowledged, and later bytes are ignored until the next start.
- R3: Bytes are shifted most significant bit first. In a write, the first byte after the address sets the pointer. Each later byte is stored at the pointer and acknowledged, and the pointer then increments.
- R4: Address 0x00 reads as {`part_id_i`[2:0], `rev_id_i`[4:0]}. Address k (1 to 6) reads as `stat_i`[8k-1:8k-8].
- R5: Writes to addresses 0x00 to 0x06 leave those locations unchanged, but the pointer still increments.
- R6: Readback is enabled while bit 6 of register 0x6C is 1 (writing 0x46 sets it). While the bit is 0, the read address is still acknowledged, but the slave never drives data bits, so the master sees 0xFF.
- R7: A read starts at the current pointer and returns consecutive addresses, with the pointer incrementing after each byte sent.
- R8: After a byte it has sent, the slave goes on if the master acknowledges. If the master does not, the slave releases the line and stays silent until the next start.
- R9: A start or stop at any bit position aborts the byte in progress and resets the bit counter. A partial byte is never stored.
- R10: `sda_oe_n_o` is an active-low pull-down enable. It is 1 in reset and in idle, and it changes only after a falling clock edge or a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Strap choosing the device address |
| part_id_i | input | 3 | Part-type code returned at address 0x00 |
| rev_id_i | input | 5 | Revision number returned at address 0x00 |
| stat_i | input | 48 | Status bytes returned at addresses 0x01 to 0x06 |
| sda_oe_n_o | output | 1 | Data-line pull-down enable, active low |

## Verification
The properties assume that the master changes the data line only while the clock is low, except to form starts and stops, and that each clock level lasts many system cycles beyond the two-flop synchroniser delay. The bench drives both lines from tasks with 40 ns and 80 ns phases, ten system cycles per clock level. It changes data only 40 ns into each low phase, and it models the bus as the wired-AND of the master's drive and the slave's pull-down. Repeated starts are formed only by raising the data line while the clock is low and dropping it while the clock is high, which matches the start rule the assertions rely on.

// File: rtl/ser_cfg_pkg.sv
`timescale 1ns/1ps
package ser_cfg_pkg;
  localparam int RO_TOP = 6;      // highest read-only address
  localparam int EN_REG = 'h6C;   // readback control register
  localparam int EN_BIT = 6;
  localparam logic [6:0] DEV_BASE = 7'h44;  // 0x88 >> 1

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } ser_st_e;
endpackage

// File: rtl/ser_sync_edge.sv
`timescale 1ns/1ps
module ser_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] sync_q [2];
  logic [1:0] last_q;
  logic [1:0] raw;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) sync_q[g] <= '1;
      else         sync_q[g] <= {sync_q[g][STAGES-2:0], raw[g]};
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 2'b11;
    else         last_q <= {scl_o, sda_o};

  assign sda_o   = sync_q[0][STAGES-1];
  assign scl_o   = sync_q[1][STAGES-1];
  assign rise_o  = scl_o & ~last_q[1];
  assign fall_o  = ~scl_o & last_q[1];
  assign start_o = scl_o & last_q[1] & last_q[0] & ~sda_o;
  assign stop_o  = scl_o & last_q[1] & ~last_q[0] & sda_o;

  AST_START_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (scl_o && $past(scl_o) && $fell(sda_o)));  // R1
endmodule

// File: rtl/ser_reg_bank.sv
`timescale 1ns/1ps
module ser_reg_bank
  import ser_cfg_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int AW = $clog2(NUM_REGS),
  localparam int RW = $clog2(RO_TOP + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [7:0]          wdata_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [7:0]          rdata_o,
  input  logic [2:0]          part_id_i,
  input  logic [4:0]          rev_id_i,
  input  logic [8*RO_TOP-1:0] stat_i,
  output logic                rd_en_o
);
  logic [7:0] mem_q [NUM_REGS];
  logic [7:0] ro_b  [RO_TOP+1];

  assign ro_b[0] = {part_id_i, rev_id_i};
  for (genvar g = 1; g <= RO_TOP; g++) begin : g_ro
    assign ro_b[g] = stat_i[8*g-1 -: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(waddr_i) > RO_TOP)) begin
      mem_q[waddr_i] <= wdata_i;
    end

  always_comb begin
    if (int'(raddr_i) <= RO_TOP) rdata_o = ro_b[raddr_i[RW-1:0]];
    else                         rdata_o = mem_q[raddr_i];
  end

  assign rd_en_o = mem_q[EN_REG][EN_BIT];
endmodule

// File: rtl/ser_cfg_slave.sv
`timescale 1ns/1ps
module ser_cfg_slave
  import ser_cfg_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                addr_sel_i,
  input  logic [2:0]          part_id_i,
  input  logic [4:0]          rev_id_i,
  input  logic [8*RO_TOP-1:0] stat_i,
  output logic                sda_oe_n_o
);
  logic scl, sda, rise, fall, start, stop;
  logic rd_en;
  logic [7:0] rdata;

  ser_st_e      st_q;
  logic [3:0]   cnt_q;
  logic [7:0]   sh_q, tx_q, wd_q;
  logic [AW-1:0] ptr_q, wa_q;
  logic         drv_q, rnw_q, first_q, mack_q, we_q;
  logic [6:0]   dev;

  assign dev = DEV_BASE | {6'd0, addr_sel_i};

  ser_sync_edge #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl), .sda_o(sda), .rise_o(rise), .fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  ser_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i, .rst_ni,
    .we_i(we_q), .waddr_i(wa_q), .wdata_i(wd_q),
    .raddr_i(ptr_q), .rdata_o(rdata),
    .part_id_i, .rev_id_i, .stat_i,
    .rd_en_o(rd_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      ptr_q <= '0; wa_q <= '0; wd_q <= '0;
      drv_q <= 1'b0; rnw_q <= 1'b0; first_q <= 1'b0; mack_q <= 1'b0; we_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start) begin
        st_q <= ST_ADDR; cnt_q <= '0; drv_q <= 1'b0;
      end else if (stop) begin
        st_q <= ST_IDLE; cnt_q <= '0; drv_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WDATA: begin
            if (rise) begin
              sh_q  <= {sh_q[6:0], sda};
              cnt_q <= cnt_q + 4'd1;
            end else if (fall && cnt_q == 4'd8) begin
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == dev) begin
                  st_q <= ST_AACK; drv_q <= 1'b1; rnw_q <= sh_q[0];
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                st_q <= ST_WACK; drv_q <= 1'b1; first_q <= 1'b0;
                if (first_q) ptr_q <= sh_q[AW-1:0];
                else begin
                  we_q <= 1'b1; wa_q <= ptr_q; wd_q <= sh_q;
                  ptr_q <= ptr_q + 1'b1;
                end
              end
            end
          end
          ST_AACK: if (fall) begin
            cnt_q <= '0;
            if (rnw_q) begin
              st_q <= ST_RDATA; tx_q <= rdata; drv_q <= rd_en & ~rdata[7];
            end else begin
              st_q <= ST_WDATA; drv_q <= 1'b0; first_q <= 1'b1;
            end
          end
          ST_WACK: if (fall) begin
            st_q <= ST_WDATA; drv_q <= 1'b0; cnt_q <= '0;
          end
          ST_RDATA: begin
            if (rise) cnt_q <= cnt_q + 4'd1;
            else if (fall) begin
              if (cnt_q == 4'd8) begin
                st_q <= ST_RACK; drv_q <= 1'b0; ptr_q <= ptr_q + 1'b1;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0}; drv_q <= rd_en & ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (rise) mack_q <= ~sda;
            else if (fall) begin
              if (mack_q) begin
                st_q <= ST_RDATA; cnt_q <= '0; tx_q <= rdata;
                drv_q <= rd_en & ~rdata[7];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe_n_o = ~drv_q;

  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (st_q == ST_IDLE && sda_oe_n_o));  // R1
  AST_START_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (st_q == ST_ADDR && cnt_q == 4'd0));  // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);  // R9
  AST_LOCKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RDATA && !rd_en) |-> sda_oe_n_o);  // R6
  AST_DRIVE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(fall) || $past(start) || $past(stop)) |-> $stable(sda_oe_n_o));  // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> sda_oe_n_o);  // R10
endmodule

// File: tb/sim_ser_cfg_slave.sv
`timescale 1ns/1ps
module sim_ser_cfg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe_n;
  wire  sda_bus = sda_m & sda_oe_n;
  logic [2:0]  part = 3'b101;
  logic [4:0]  rev  = 5'h0B;
  logic [47:0] stat = 48'h6655_4433_2211;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [4];

  always #4 clk = ~clk;  // 125 MHz

  ser_cfg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .part_id_i(part), .rev_id_i(rev),
    .stat_i(stat), .sda_oe_n_o(sda_oe_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #40; scl_m = 1'b1; #80; sda_m = 1'b0; #80; scl_m = 1'b0; #40;
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; #40; scl_m = 1'b1; #80; sda_m = 1'b1; #80;
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; #40; scl_m = 1'b1; #80; scl_m = 1'b0; #40;
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; #40; scl_m = 1'b1; #40; b = sda_bus; #40; scl_m = 1'b0; #40;
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
    put_bit(~mack);
  endtask

  task automatic wr_seq(input logic [7:0] dev, input logic [7:0] sub,
                        input logic [7:0] d0, d1, d2, input int n, output logic all_ack);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(dev, a); all_ack = a;
    send_byte(sub, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin send_byte(d[i], a); all_ack &= a; end
    bus_stop();
  endtask
  task automatic rd_seq(input logic [7:0] dev, input int n, output logic ack);
    bus_start();
    send_byte(dev, ack);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R10 idle release", {7'd0, sda_oe_n}, 8'h01);
  endtask

  task automatic t_locked_read();
    logic ok;
    wr_seq(8'h88, 8'h00, 0, 0, 0, 0, ok);
    chk("R2 address ack", {7'd0, ok}, 8'h01);
    rd_seq(8'h89, 1, ok);
    chk("R6 read addr ack while locked", {7'd0, ok}, 8'h01);
    chk("R6 locked data", rbuf[0], 8'hFF);
  endtask

  task automatic t_enable_and_id();
    logic ok;
    wr_seq(8'h88, 8'h6C, 8'h46, 0, 0, 1, ok);
    chk("R3 write acks", {7'd0, ok}, 8'h01);
    wr_seq(8'h88, 8'h00, 0, 0, 0, 0, ok);
    rd_seq(8'h89, 3, ok);
    chk("R4 id byte", rbuf[0], 8'hAB);
    chk("R4 status byte 1", rbuf[1], 8'h11);
    chk("R7 auto increment", rbuf[2], 8'h22);
  endtask

  task automatic t_burst();
    logic ok;
    wr_seq(8'h88, 8'h10, 8'hA5, 8'h3C, 8'hF0, 3, ok);
    chk("R3 burst acks", {7'd0, ok}, 8'h01);
    wr_seq(8'h88, 8'h10, 0, 0, 0, 0, ok);
    rd_seq(8'h89, 3, ok);
    chk("R3 byte0", rbuf[0], 8'hA5);
    chk("R3 byte1", rbuf[1], 8'h3C);
    chk("R7 byte2", rbuf[2], 8'hF0);
    // pointer left after a write burst
    wr_seq(8'h88, 8'h32, 8'h77, 0, 0, 1, ok);
    wr_seq(8'h88, 8'h30, 8'h11, 8'h22, 0, 2, ok);
    rd_seq(8'h89, 1, ok);
    chk("R7 continue from pointer", rbuf[0], 8'h77);
  endtask

  task automatic t_ro();
    logic ok;
    wr_seq(8'h88, 8'h06, 8'h12, 8'h99, 0, 2, ok);
    wr_seq(8'h88, 8'h06, 0, 0, 0, 0, ok);
    rd_seq(8'h89, 2, ok);
    chk("R5 read-only kept", rbuf[0], 8'h66);
    chk("R5 pointer advanced", rbuf[1], 8'h99);
  endtask

  task automatic t_nack_end();
    logic ok, x;
    logic [7:0] v;
    wr_seq(8'h88, 8'h12, 0, 0, 0, 0, ok);
    bus_start();
    send_byte(8'h89, ok);
    recv_byte(v, 1'b0);
    chk("R8 single byte", v, 8'hF0);
    for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
    get_bit(x);
    chk("R8 silent after nack", v, 8'hFF);
    chk("R1 no ack without start", {7'd0, x}, 8'h01);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'h90, a);
    chk("R2 mismatch nack", {7'd0, a}, 8'h00);
    send_byte(8'h10, a);
    chk("R2 ignored after mismatch", {7'd0, a}, 8'h00);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ok, a;
    wr_seq(8'h88, 8'h40, 8'h55, 8'h66, 0, 2, ok);
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h40, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();  // repeated start mid-byte
    send_byte(8'h89, a);
    chk("R9 ack after restart", {7'd0, a}, 8'h01);
    recv_byte(rbuf[0], 1'b1);
    recv_byte(rbuf[1], 1'b0);
    bus_stop();
    chk("R9 partial byte discarded", rbuf[0], 8'h55);
    chk("R9 next byte intact", rbuf[1], 8'h66);
  endtask

  task automatic t_strap();
    logic ok;
    addr_sel = 1'b1;
    #40;
    wr_seq(8'h88, 8'h10, 0, 0, 0, 0, ok);
    chk("R2 old address refused", {7'd0, ok}, 8'h00);
    wr_seq(8'h8A, 8'h11, 0, 0, 0, 0, ok);
    chk("R2 strap address ack", {7'd0, ok}, 8'h01);
    rd_seq(8'h8B, 1, ok);
    chk("R2 strap read", rbuf[0], 8'h3C);
    addr_sel = 1'b0;
    #40;
  endtask

  task automatic t_relock();
    logic ok;
    wr_seq(8'h88, 8'h6C, 8'h06, 0, 0, 1, ok);
    wr_seq(8'h88, 8'h10, 0, 0, 0, 0, ok);
    rd_seq(8'h89, 1, ok);
    chk("R6 relocked", rbuf[0], 8'hFF);
  endtask

  initial begin
    #23 rst_n = 1'b1;
    #20;
    t_reset();
    t_locked_read();
    t_enable_and_id();
    t_burst();
    t_ro();
    t_nack_end();
    t_mismatch();
    t_abort();
    t_strap();
    t_relock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule